// File: doc/BRIEF.md
# Host Command Vector Interrupt Logic

This block lets an external host processor make an embedded signal-processing core take an exception of the host's choosing. The host sees one 8-bit command word. It writes a 5-bit vector number into that word and raises the command bit. The core sees a control word that holds an interrupt enable, and a status word that holds a pending flag. The block drives an interrupt request that carries a program address equal to twice the vector number.

When the core acknowledges the exception, the command bit and the pending flag clear in hardware, with no action from the host. The host therefore polls the command bit as a busy indication. While a command is outstanding, the host cannot change the vector.

A three-state machine sequences a command. `ST_IDLE` means no command is outstanding. `ST_MASKED` means a command is pending but the enable is off. `ST_REQUEST` means a command is pending and the request is driven. The transitions are:
- `START_MASKED`: `ST_IDLE` to `ST_MASKED`, on a host write with the command bit set while the enable is 0.
- `START_REQ`: `ST_IDLE` to `ST_REQUEST`, on the same write while the enable is 1.
- `UNMASK`: `ST_MASKED` to `ST_REQUEST`, when the enable is set.
- `MASK`: `ST_REQUEST` to `ST_MASKED`, when the enable is cleared.
- `ACK_CLEAR`: `ST_MASKED` or `ST_REQUEST` to `ST_IDLE`, on acknowledge.

Top module: `host_cmd_vector`

## Requirements
- R1: After reset, `host_rdata` reads 0x12, `dsp_stat_rdata` and `dsp_ctrl_rdata` read 0x00, `irq_req` is 0 and `irq_vaddr` is 0x0024.
- R2: `host_rdata` has the command bit at bit 7 and the vector at bits 4..0, and bits 6..5 always read 0.
- R3: A host write with bit 7 = 0 while idle loads bits 4..0 into the vector from the next cycle and starts no command.
- R4: A host write with bit 7 = 1 while idle loads the vector. From the next cycle, bit 7 of `host_rdata` and the pending flag (bit 2 of `dsp_stat_rdata`) both read 1.
- R5: `irq_vaddr` always equals the vector times 2, zero-extended: vector 0 gives 0x0000 and vector 0x1F gives 0x003E.
- R6: `irq_req` is 1 exactly when both the pending flag and the enable (bit 2 of `dsp_ctrl_rdata`) are 1. While the enable is 0, the pending flag still sets.
- R7: A one-cycle `irq_ack` while a command is pending, masked or not, clears the command bit and the pending flag. From the cycle after the pulse, `irq_req` is 0.
- R8: While the command bit is 1, host writes are ignored: the vector and the command bit keep their values.
- R9: A write to the control word sets the enable from bit 2 only. Every other bit of `dsp_ctrl_rdata` reads 0.
- R10: Every bit of `dsp_stat_rdata` other than bit 2 reads 0.
- R11: `irq_ack` while idle has no effect on any output.
- R12: Clearing the enable while pending drops `irq_req` from the next cycle and keeps the flag set. Setting the enable again raises `irq_req` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host view of the command word |
| dsp_ctrl_wr | input | 1 | Core write strobe for the control word |
| dsp_ctrl_wdata | input | 8 | Core control write data |
| dsp_ctrl_rdata | output | 8 | Core view of the control word |
| dsp_stat_rdata | output | 8 | Core view of the status word |
| irq_ack | input | 1 | One-cycle exception acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_vaddr | output | 16 | Exception vector address |

## Verification
A plain vector write is compared with a command write. This separates loading the vector from starting a command. Commands are started with the enable both on and off, which shows that the pending flag is independent of the request mask. The enable is toggled mid-command and the core acknowledges in the masked state, to exercise each state transition. Host writes are made during a pending command, and an acknowledge is given while idle, to show that those inputs change nothing. The vectors 0, the reset value and 0x1F probe both ends of the address mapping.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MASKED  = 2'd1,
        ST_REQUEST = 2'd2
    } hcv_state_e;

    // Bit positions that the host and core software decode
    localparam int CMD_BIT  = 7;
    localparam int PEND_BIT = 2;
    localparam int EN_BIT   = 2;
endpackage

// File: rtl/hcv_vector_reg.sv
module hcv_vector_reg #(
    parameter int          DATA_W = 8,
    parameter int          HV_W   = 5,
    parameter logic [4:0]  HV_RST = 5'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [HV_W-1:0]   wr_hv,
    input  logic              busy,
    output logic [HV_W-1:0]   hv,
    output logic [DATA_W-1:0] rd_word
);
    import hcv_pkg::*;

    logic load;

    // The vector is frozen while a command is outstanding
    assign load = wr && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv <= HV_RST[HV_W-1:0];
        end else if (load) begin
            hv <= wr_hv;
        end
    end

    always_comb begin
        rd_word          = '0;
        rd_word[HV_W-1:0] = hv;
        rd_word[CMD_BIT]  = busy;
    end
endmodule

// File: rtl/hcv_ctrl_reg.sv
module hcv_ctrl_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_en_bit,
    output logic              en,
    output logic              en_nxt,
    output logic [DATA_W-1:0] rd_word
);
    import hcv_pkg::*;

    always_comb begin
        en_nxt = wr ? wr_en_bit : en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else begin
            en <= en_nxt;
        end
    end

    always_comb begin
        rd_word         = '0;
        rd_word[EN_BIT] = en;
    end
endmodule

// File: rtl/hcv_fsm.sv
module hcv_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en_nxt,
    input  logic ack,
    output logic pending,
    output logic req
);
    import hcv_pkg::*;

    hcv_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = en_nxt ? ST_REQUEST : ST_MASKED;  // START_REQ / START_MASKED
                end
            end
            ST_MASKED: begin
                if (ack) begin
                    state_nxt = ST_IDLE;                          // ACK_CLEAR
                end else if (en_nxt) begin
                    state_nxt = ST_REQUEST;                       // UNMASK
                end
            end
            ST_REQUEST: begin
                if (ack) begin
                    state_nxt = ST_IDLE;                          // ACK_CLEAR
                end else if (!en_nxt) begin
                    state_nxt = ST_MASKED;                        // MASK
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = 1'b0;
        req     = 1'b0;
        unique case (state)
            ST_IDLE:    begin pending = 1'b0; req = 1'b0; end
            ST_MASKED:  begin pending = 1'b1; req = 1'b0; end
            ST_REQUEST: begin pending = 1'b1; req = 1'b1; end
            default:    begin pending = 1'b0; req = 1'b0; end
        endcase
    end
endmodule

// File: rtl/hcv_addr_map.sv
module hcv_addr_map #(
    parameter int HV_W   = 5,
    parameter int ADDR_W = 16
) (
    input  logic [HV_W-1:0]   hv,
    output logic [ADDR_W-1:0] vaddr
);
    localparam int SHIFTED_W = HV_W + 1;

    logic [SHIFTED_W-1:0] shifted;
    assign shifted = {hv, 1'b0};

    generate
        if (ADDR_W > SHIFTED_W) begin : g_pad
            assign vaddr = {{(ADDR_W-SHIFTED_W){1'b0}}, shifted};
        end else begin : g_trunc
            assign vaddr = shifted[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/host_cmd_vector.sv
module host_cmd_vector #(
    parameter int         DATA_W = 8,
    parameter int         HV_W   = 5,
    parameter int         ADDR_W = 16,
    parameter logic [4:0] HV_RST = 5'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dsp_ctrl_wr,
    input  logic [DATA_W-1:0] dsp_ctrl_wdata,
    output logic [DATA_W-1:0] dsp_ctrl_rdata,
    output logic [DATA_W-1:0] dsp_stat_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vaddr
);
    import hcv_pkg::*;

    logic            pending;
    logic            en;
    logic            en_nxt;
    logic            start;
    logic [HV_W-1:0] hv;
    logic            unused_wdata;

    assign unused_wdata = ^{host_wdata, dsp_ctrl_wdata, en};
    assign start        = host_wr && host_wdata[CMD_BIT];

    hcv_vector_reg #(.DATA_W(DATA_W), .HV_W(HV_W), .HV_RST(HV_RST)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .wr_hv   (host_wdata[HV_W-1:0]),
        .busy    (pending),
        .hv      (hv),
        .rd_word (host_rdata)
    );

    hcv_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (dsp_ctrl_wr),
        .wr_en_bit (dsp_ctrl_wdata[EN_BIT]),
        .en        (en),
        .en_nxt    (en_nxt),
        .rd_word   (dsp_ctrl_rdata)
    );

    hcv_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .en_nxt  (en_nxt),
        .ack     (irq_ack),
        .pending (pending),
        .req     (irq_req)
    );

    hcv_addr_map #(.HV_W(HV_W), .ADDR_W(ADDR_W)) u_map (
        .hv    (hv),
        .vaddr (irq_vaddr)
    );

    always_comb begin
        dsp_stat_rdata           = '0;
        dsp_stat_rdata[PEND_BIT] = pending;
    end
endmodule

// File: rtl/hcv_checker.sv
module hcv_checker #(
    parameter int DATA_W = 8,
    parameter int HV_W   = 5,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [DATA_W-1:0] dsp_ctrl_rdata,
    input logic [DATA_W-1:0] dsp_stat_rdata,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [ADDR_W-1:0] irq_vaddr
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[6:5] == 2'b00);

    p_start_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[7] && !host_rdata[7]) |=> (dsp_stat_rdata[2] && host_rdata[7]));

    p_vaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vaddr == ADDR_W'({host_rdata[HV_W-1:0], 1'b0}));

    p_req_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (dsp_stat_rdata[2] && dsp_ctrl_rdata[2]));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!dsp_stat_rdata[2] && !host_rdata[7] && !irq_req));

    p_hv_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[7] && !irq_ack) |=> ($stable(host_rdata) && host_rdata[7]));
endmodule

bind host_cmd_vector hcv_checker #(.DATA_W(DATA_W), .HV_W(HV_W), .ADDR_W(ADDR_W)) u_hcv_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_wr        (host_wr),
    .host_wdata     (host_wdata),
    .host_rdata     (host_rdata),
    .dsp_ctrl_rdata (dsp_ctrl_rdata),
    .dsp_stat_rdata (dsp_stat_rdata),
    .irq_ack        (irq_ack),
    .irq_req        (irq_req),
    .irq_vaddr      (irq_vaddr)
);

// File: tb/tb_host_cmd_vector.sv
module tb_host_cmd_vector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        dsp_ctrl_wr = 1'b0;
    logic [7:0]  dsp_ctrl_wdata = '0;
    logic [7:0]  dsp_ctrl_rdata;
    logic [7:0]  dsp_stat_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vaddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_cmd_vector dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_wr        (host_wr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .dsp_ctrl_wr    (dsp_ctrl_wr),
        .dsp_ctrl_wdata (dsp_ctrl_wdata),
        .dsp_ctrl_rdata (dsp_ctrl_rdata),
        .dsp_stat_rdata (dsp_stat_rdata),
        .irq_ack        (irq_ack),
        .irq_req        (irq_req),
        .irq_vaddr      (irq_vaddr)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        host_wr = 1'b1; host_wdata = v;
        step();
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic ctrl_write(input logic [7:0] v);
        dsp_ctrl_wr = 1'b1; dsp_ctrl_wdata = v;
        step();
        dsp_ctrl_wr = 1'b0; dsp_ctrl_wdata = '0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 host_rdata", host_rdata, 8'h12);
        check("R1 stat", dsp_stat_rdata, 8'h00);
        check("R1 ctrl", dsp_ctrl_rdata, 8'h00);
        check("R1 irq_req", irq_req, 1'b0);
        check("R1 vaddr", irq_vaddr, 16'h0024);
    endtask

    task automatic t_plain_write();
        host_write(8'h7F);   // bits 6..5 set in the write, must read 0
        check("R2 R3 host_rdata", host_rdata, 8'h1F);
        check("R3 stat", dsp_stat_rdata, 8'h00);
        check("R5 vaddr max", irq_vaddr, 16'h003E);
        host_write(8'h00);
        check("R3 host_rdata zero", host_rdata, 8'h00);
        check("R5 vaddr zero", irq_vaddr, 16'h0000);
    endtask

    task automatic t_ack_idle();
        host_write(8'h09);
        ack_pulse();
        check("R11 host_rdata", host_rdata, 8'h09);
        check("R11 stat", dsp_stat_rdata, 8'h00);
        check("R11 irq_req", irq_req, 1'b0);
    endtask

    task automatic t_ctrl_bits();
        ctrl_write(8'hFF);
        check("R9 ctrl all ones", dsp_ctrl_rdata, 8'h04);
        ctrl_write(8'hFB);
        check("R9 ctrl bit2 clear", dsp_ctrl_rdata, 8'h00);
    endtask

    task automatic t_cmd_enabled();
        ctrl_write(8'h04);
        host_write(8'h87);
        check("R4 host_rdata", host_rdata, 8'h87);
        check("R4 R10 stat", dsp_stat_rdata, 8'h04);
        check("R6 irq_req on", irq_req, 1'b1);
        check("R5 vaddr", irq_vaddr, 16'h000E);
        ack_pulse();
        check("R7 irq_req off", irq_req, 1'b0);
        check("R7 host_rdata", host_rdata, 8'h07);
        check("R7 stat", dsp_stat_rdata, 8'h00);
    endtask

    task automatic t_cmd_masked();
        ctrl_write(8'h00);
        host_write(8'h85);
        check("R6 masked stat", dsp_stat_rdata, 8'h04);
        check("R6 masked irq_req", irq_req, 1'b0);
        host_write(8'h1F);
        check("R8 write ignored", host_rdata, 8'h85);
        host_write(8'h00);
        check("R8 clear ignored", host_rdata, 8'h85);
        check("R8 vaddr", irq_vaddr, 16'h000A);
        ctrl_write(8'h04);
        check("R12 unmask", irq_req, 1'b1);
        ctrl_write(8'h00);
        check("R12 mask irq_req", irq_req, 1'b0);
        check("R12 mask stat", dsp_stat_rdata, 8'h04);
        ack_pulse();
        check("R7 masked ack host", host_rdata, 8'h05);
        check("R7 masked ack stat", dsp_stat_rdata, 8'h00);
        ctrl_write(8'h04);
        check("R7 no req after ack", irq_req, 1'b0);
        ctrl_write(8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_plain_write();
        t_ack_idle();
        t_ctrl_bits();
        t_cmd_enabled();
        t_cmd_masked();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule